// File: doc/BRIEF.md
# Voltage Set-Point I2C Write Sequencer

This block is a processor-free bus master that pushes voltage set-point words out to remote trim devices over I2C. Surrounding logic presents a vector of pending channel requests. The sequencer picks one channel in round-robin order and presents its index on `sel_ch`. It then captures the 7-bit slave address, the register pointer and the 13-bit set-point that the surrounding logic looks up for that index. The whole transaction runs through an 8-bit WISHBONE master port. That port drives the register interface of an embedded byte-level I2C controller and, when enabled, a mutex peripheral that arbitrates ownership of that controller.

For each request the sequencer does the following in order. It claims the mutex. It polls until the external bus is idle. It drops the write-protect line and writes the word as a low byte then a high byte. It raises write-protect again and reads both bytes back. The request is retired only when the read-back word equals the word written. A lost arbitration during the write phase sends the machine back to the bus-idle poll with write-protect raised, and the write is then sent again. A missing acknowledge or a read-back mismatch leaves the request pending for a later round-robin pass. A programmable number of slow-clock ticks separates successive request transactions.

Top module: `vsq_setpoint_seq`

## Requirements
- R1: While no request is pending and the sequencer is not working, `sel_valid` stays low and no WISHBONE cycle is started. Every WISHBONE cycle occurs while `sel_valid` is high.
- R2: Every WISHBONE access holds `wb_cyc` and `wb_stb` high, with address, data and `wb_we` unchanged, until `wb_ack` arrives. `wb_we` is 1 for writes and 0 for reads.
- R3: With the mutex enabled, the sequencer writes `{1, OWNER_ID}` to the mutex address (default 0x40). It reads the mutex back and repeats the write/read pair until the value read is `{1, OWNER_ID}`. It touches no I2C controller register before that. After the transaction it writes `{0, OWNER_ID}` to release the mutex.
- R4: Before the first byte of a write phase, the sequencer reads the status register (default 0x23) until its bit 0 (bus busy) is 0. Only after that read does it drive `wr_prot` low.
- R5: Bytes go through the transmit register (0x21), and each byte is started by a write to the command register (0x20). The command bits are: bit 0 START, bit 1 STOP, bit 2 WRITE, bit 3 READ, bit 4 NACK-on-read. The write phase is START+{addr,0}, pointer, low byte, then high byte `{000, data[12:8]}` with STOP. The read-back phase is START+{addr,0}, pointer, START+{addr,1}, READ, then READ with NACK and STOP. Receive data comes from address 0x22.
- R6: After each command the sequencer polls status until bit 1 (transfer in progress) is 0. If bit 2 (arbitration lost) is set during the write phase, it raises `wr_prot` and returns to the bus-busy poll. It then retransmits the write phase from the address byte while keeping the mutex.
- R7: `req_clr` pulses the one-hot bit of the served channel for one cycle, and only when the 16-bit read-back equals the zero-extended set-point. On a mismatch the request stays pending and is retried later.
- R8: If status bit 3 (no acknowledge) is set after a transmitted byte, the attempt ends. `wr_prot` goes high, the mutex is released, and the request stays pending.
- R9: A new request is taken from the first pending channel after the last served channel, in increasing index order with wrap-around. This order holds whether the previous attempt succeeded or not.
- R10: After each request transaction, the next selection starts only after exactly `WAIT_TICKS` `slow_tick` pulses. It starts within four clock cycles after the last of those pulses.
- R11: `wr_prot` is high out of reset and whenever `sel_valid` is low. It is low only between the bus-idle check and the end of the write phase.

Top module ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle pulse per slow-clock tick, already in the `clk` domain |
| req_pend | input | NCH | Pending request per channel |
| sel_valid | output | 1 | A request transaction is in progress for `sel_ch` |
| sel_ch | output | CHW | Channel being served |
| tgt_addr | input | 7 | 7-bit I2C slave address for `sel_ch` |
| tgt_ptr | input | 8 | Set-point register pointer for `sel_ch` |
| tgt_data | input | 13 | Set-point word for `sel_ch` |
| req_clr | output | NCH | One-cycle one-hot retire pulse after verified write |
| wb_cyc | output | 1 | WISHBONE cycle |
| wb_stb | output | 1 | WISHBONE strobe |
| wb_we | output | 1 | WISHBONE write enable |
| wb_adr | output | ADR_W | WISHBONE address |
| wb_dat_o | output | 8 | WISHBONE write data |
| wb_dat_i | input | 8 | WISHBONE read data |
| wb_ack | input | 1 | WISHBONE acknowledge |
| wr_prot | output | 1 | Write-protect to target devices, high = protected |

## Verification
A wrong state code shows at the ports within one bus access. It shows up as a WISHBONE address or command byte that is out of sequence, or as write-protect low outside a write phase. A lost or corrupted byte index shows up after the read-back as a stored word that differs from the table value, or as a retire pulse that is missing. A broken round-robin pointer or a broken tick counter appears at the next selection: it shows as the wrong `sel_ch` or a gap of the wrong length between transactions. The directed tests therefore inject controller faults in turn: a busy bus, a contended mutex, lost arbitration, a missing acknowledge and a corrupted read-back. Each test then checks the target memory and the retire pulses, and counts the protocol violations seen by the controller model.

// File: rtl/vsq_pkg.sv
package vsq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LOAD,
        S_MTX_REQ,
        S_MTX_CHK,
        S_BUS_POLL,
        S_TX,
        S_CMD,
        S_POLL,
        S_RX,
        S_MTX_REL,
        S_DONE,
        S_WAIT
    } vsq_state_e;

    // status register bits of the I2C controller
    localparam int ST_BUSY = 0;
    localparam int ST_TIP  = 1;
    localparam int ST_ARBL = 2;
    localparam int ST_NACK = 3;

    // command register bits of the I2C controller
    localparam int CM_START = 0;
    localparam int CM_STOP  = 1;
    localparam int CM_WRITE = 2;
    localparam int CM_READ  = 3;
    localparam int CM_NAK   = 4;

    // byte slots of one request transaction
    localparam logic [3:0] IDX_LAST_WR  = 4'd3;
    localparam logic [3:0] IDX_FIRST_RX = 4'd7;
    localparam logic [3:0] IDX_LAST     = 4'd8;

    function automatic logic idx_is_rx(input logic [3:0] i);
        return i >= IDX_FIRST_RX;
    endfunction

endpackage

// File: rtl/vsq_rr_pick.sv
module vsq_rr_pick #(
    parameter int NCH = 8,
    parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] pend,
    input  logic [CHW-1:0] last,
    output logic           any,
    output logic [CHW-1:0] pick
);

    // scan from the slot after 'last'; the nearest pending slot wins
    always_comb begin
        any  = 1'b0;
        pick = '0;
        for (int k = NCH - 1; k >= 0; k--) begin
            int c;
            c = (int'(last) + 1 + k) % NCH;
            if (pend[c]) begin
                any  = 1'b1;
                pick = CHW'(c);
            end
        end
    end

endmodule

// File: rtl/vsq_byte_plan.sv
module vsq_byte_plan
    import vsq_pkg::*;
(
    input  logic [3:0]  idx,
    input  logic [6:0]  addr,
    input  logic [7:0]  ptr,
    input  logic [12:0] data,
    output logic [7:0]  txd,
    output logic [7:0]  cmd
);

    always_comb begin
        txd = '0;
        cmd = '0;
        case (idx)
            4'd0: begin txd = {addr, 1'b0}; cmd[CM_START] = 1'b1; cmd[CM_WRITE] = 1'b1; end
            4'd1: begin txd = ptr;          cmd[CM_WRITE] = 1'b1; end
            4'd2: begin txd = data[7:0];    cmd[CM_WRITE] = 1'b1; end
            4'd3: begin txd = {3'b000, data[12:8]}; cmd[CM_WRITE] = 1'b1; cmd[CM_STOP] = 1'b1; end
            4'd4: begin txd = {addr, 1'b0}; cmd[CM_START] = 1'b1; cmd[CM_WRITE] = 1'b1; end
            4'd5: begin txd = ptr;          cmd[CM_WRITE] = 1'b1; end
            4'd6: begin txd = {addr, 1'b1}; cmd[CM_START] = 1'b1; cmd[CM_WRITE] = 1'b1; end
            4'd7: begin cmd[CM_READ] = 1'b1; end
            4'd8: begin cmd[CM_READ] = 1'b1; cmd[CM_NAK] = 1'b1; cmd[CM_STOP] = 1'b1; end
            default: begin txd = '0; cmd = '0; end
        endcase
    end

endmodule

// File: rtl/vsq_tick_wait.sv
module vsq_tick_wait #(
    parameter int WAIT_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    output logic busy
);

    localparam int CW = (WAIT_TICKS < 2) ? 1 : $clog2(WAIT_TICKS + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CW'(WAIT_TICKS);
        end else if (tick && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/vsq_setpoint_seq.sv
module vsq_setpoint_seq
    import vsq_pkg::*;
#(
    parameter int            NCH          = 8,
    parameter int            ADR_W        = 8,
    parameter int            WAIT_TICKS   = 3,
    parameter bit            MUTEX_EN     = 1'b1,
    parameter logic [7:0]    MUTEX_ADR    = 8'h40,
    parameter logic [6:0]    OWNER_ID     = 7'h05,
    parameter logic [7:0]    I2C_CMD_ADR  = 8'h20,
    parameter logic [7:0]    I2C_TXD_ADR  = 8'h21,
    parameter logic [7:0]    I2C_RXD_ADR  = 8'h22,
    parameter logic [7:0]    I2C_STAT_ADR = 8'h23,
    localparam int           CHW          = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_tick,
    input  logic [NCH-1:0]   req_pend,
    output logic             sel_valid,
    output logic [CHW-1:0]   sel_ch,
    input  logic [6:0]       tgt_addr,
    input  logic [7:0]       tgt_ptr,
    input  logic [12:0]      tgt_data,
    output logic [NCH-1:0]   req_clr,
    output logic             wb_cyc,
    output logic             wb_stb,
    output logic             wb_we,
    output logic [ADR_W-1:0] wb_adr,
    output logic [7:0]       wb_dat_o,
    input  logic [7:0]       wb_dat_i,
    input  logic             wb_ack,
    output logic             wr_prot
);

    typedef struct packed {
        vsq_state_e     st;
        logic [CHW-1:0] ch;
        logic [CHW-1:0] last;
        logic [6:0]     addr;
        logic [7:0]     ptr;
        logic [12:0]    data;
        logic [3:0]     idx;
        logic [7:0]     rdlo;
        logic           wp;
        logic           ok;
    } seq_t;

    seq_t q, n;

    logic           rr_any;
    logic [CHW-1:0] rr_sel;
    logic [7:0]     plan_txd, plan_cmd;
    logic           tmr_load, tmr_busy;
    vsq_state_e     after_xfer;

    assign after_xfer = MUTEX_EN ? S_MTX_REL : S_DONE;

    vsq_rr_pick #(.NCH(NCH), .CHW(CHW)) u_rr (
        .pend (req_pend),
        .last (q.last),
        .any  (rr_any),
        .pick (rr_sel)
    );

    vsq_byte_plan u_plan (
        .idx  (q.idx),
        .addr (q.addr),
        .ptr  (q.ptr),
        .data (q.data),
        .txd  (plan_txd),
        .cmd  (plan_cmd)
    );

    vsq_tick_wait #(.WAIT_TICKS(WAIT_TICKS)) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .tick  (slow_tick),
        .busy  (tmr_busy)
    );

    // bus outputs decoded from the registered state only
    always_comb begin
        wb_cyc   = 1'b0;
        wb_we    = 1'b0;
        wb_adr   = '0;
        wb_dat_o = '0;
        case (q.st)
            S_MTX_REQ:  begin wb_cyc = 1'b1; wb_we = 1'b1; wb_adr = ADR_W'(MUTEX_ADR); wb_dat_o = {1'b1, OWNER_ID}; end
            S_MTX_CHK:  begin wb_cyc = 1'b1; wb_adr = ADR_W'(MUTEX_ADR); end
            S_MTX_REL:  begin wb_cyc = 1'b1; wb_we = 1'b1; wb_adr = ADR_W'(MUTEX_ADR); wb_dat_o = {1'b0, OWNER_ID}; end
            S_BUS_POLL: begin wb_cyc = 1'b1; wb_adr = ADR_W'(I2C_STAT_ADR); end
            S_POLL:     begin wb_cyc = 1'b1; wb_adr = ADR_W'(I2C_STAT_ADR); end
            S_TX:       begin wb_cyc = 1'b1; wb_we = 1'b1; wb_adr = ADR_W'(I2C_TXD_ADR); wb_dat_o = plan_txd; end
            S_CMD:      begin wb_cyc = 1'b1; wb_we = 1'b1; wb_adr = ADR_W'(I2C_CMD_ADR); wb_dat_o = plan_cmd; end
            S_RX:       begin wb_cyc = 1'b1; wb_adr = ADR_W'(I2C_RXD_ADR); end
            default:    begin wb_cyc = 1'b0; end
        endcase
    end

    assign wb_stb    = wb_cyc;
    assign wr_prot   = q.wp;
    assign sel_ch    = q.ch;
    assign sel_valid = (q.st != S_IDLE) && (q.st != S_WAIT);
    assign req_clr   = (q.st == S_DONE && q.ok) ? (NCH'(1) << q.ch) : '0;

    always_comb begin
        n        = q;
        tmr_load = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (rr_any) begin
                    n.ch = rr_sel;
                    n.st = S_LOAD;
                end
            end
            S_LOAD: begin
                n.addr = tgt_addr;
                n.ptr  = tgt_ptr;
                n.data = tgt_data;
                n.idx  = '0;
                n.ok   = 1'b0;
                n.st   = MUTEX_EN ? S_MTX_REQ : S_BUS_POLL;
            end
            S_MTX_REQ: begin
                if (wb_ack) n.st = S_MTX_CHK;
            end
            S_MTX_CHK: begin
                if (wb_ack) n.st = (wb_dat_i == {1'b1, OWNER_ID}) ? S_BUS_POLL : S_MTX_REQ;
            end
            S_BUS_POLL: begin
                if (wb_ack && !wb_dat_i[ST_BUSY]) begin
                    n.wp  = 1'b0;
                    n.idx = '0;
                    n.st  = S_TX;
                end
            end
            S_TX: begin
                if (wb_ack) n.st = S_CMD;
            end
            S_CMD: begin
                if (wb_ack) n.st = S_POLL;
            end
            S_POLL: begin
                if (wb_ack && !wb_dat_i[ST_TIP]) begin
                    if (wb_dat_i[ST_ARBL]) begin
                        n.wp = 1'b1;
                        n.st = (q.idx <= IDX_LAST_WR) ? S_BUS_POLL : after_xfer;
                    end else if (wb_dat_i[ST_NACK] && !idx_is_rx(q.idx)) begin
                        n.wp = 1'b1;
                        n.st = after_xfer;
                    end else if (idx_is_rx(q.idx)) begin
                        n.st = S_RX;
                    end else begin
                        if (q.idx == IDX_LAST_WR) n.wp = 1'b1;
                        n.idx = q.idx + 4'd1;
                        n.st  = idx_is_rx(q.idx + 4'd1) ? S_CMD : S_TX;
                    end
                end
            end
            S_RX: begin
                if (wb_ack) begin
                    if (q.idx != IDX_LAST) begin
                        n.rdlo = wb_dat_i;
                        n.idx  = q.idx + 4'd1;
                        n.st   = S_CMD;
                    end else begin
                        n.ok = ({wb_dat_i, q.rdlo} == {3'b000, q.data});
                        n.st = after_xfer;
                    end
                end
            end
            S_MTX_REL: begin
                if (wb_ack) n.st = S_DONE;
            end
            S_DONE: begin
                n.last   = q.ch;
                n.wp     = 1'b1;
                tmr_load = 1'b1;
                n.st     = S_WAIT;
            end
            S_WAIT: begin
                if (!tmr_busy) n.st = S_IDLE;
            end
            default: n.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
            q.last <= CHW'(NCH - 1);
            q.wp   <= 1'b1;
        end else begin
            q <= n;
        end
    end

endmodule

// File: rtl/vsq_seq_checker.sv
module vsq_seq_checker
    import vsq_pkg::*;
#(
    parameter int         NCH      = 8,
    parameter int         ADR_W    = 8,
    parameter logic [7:0] STAT_ADR = 8'h23,
    localparam int        CHW      = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCH-1:0]   req_pend,
    input logic             sel_valid,
    input logic [CHW-1:0]   sel_ch,
    input logic [NCH-1:0]   req_clr,
    input logic             wb_cyc,
    input logic             wb_stb,
    input logic             wb_we,
    input logic [ADR_W-1:0] wb_adr,
    input logic [7:0]       wb_dat_o,
    input logic [7:0]       wb_dat_i,
    input logic             wb_ack,
    input logic             wr_prot
);

    assert_bus_needs_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc |-> sel_valid);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_valid && req_pend == '0) |=> !sel_valid);

    assert_stb_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb && !wb_ack) |=> (wb_stb && $stable(wb_adr) && $stable(wb_we) && $stable(wb_dat_o)));

    assert_wp_after_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_prot) |-> $past(wb_ack && !wb_we && wb_adr == ADR_W'(STAT_ADR)
                                 && ((wb_dat_i & (8'd1 << ST_BUSY)) == 8'd0)));

    assert_clr_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_clr));

    assert_clr_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_clr != '0) |-> ((req_clr & req_pend) == req_clr));

    assert_sel_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && $past(sel_valid)) |-> $stable(sel_ch));

    assert_wp_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |-> wr_prot);

endmodule

bind vsq_setpoint_seq vsq_seq_checker #(
    .NCH      (NCH),
    .ADR_W    (ADR_W),
    .STAT_ADR (I2C_STAT_ADR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_pend  (req_pend),
    .sel_valid (sel_valid),
    .sel_ch    (sel_ch),
    .req_clr   (req_clr),
    .wb_cyc    (wb_cyc),
    .wb_stb    (wb_stb),
    .wb_we     (wb_we),
    .wb_adr    (wb_adr),
    .wb_dat_o  (wb_dat_o),
    .wb_dat_i  (wb_dat_i),
    .wb_ack    (wb_ack),
    .wr_prot   (wr_prot)
);

// File: tb/tb_vsq_setpoint_seq.sv
module tb_vsq_setpoint_seq;

    localparam int         NCH   = 8;
    localparam int         W     = 3;
    localparam logic [6:0] OWN   = 7'h05;
    localparam logic [6:0] TADDR = 7'h2A;
    localparam logic [7:0] A_CMD = 8'h20, A_TXD = 8'h21, A_RXD = 8'h22, A_STAT = 8'h23, A_MTX = 8'h40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slow_tick = 1'b0;
    logic [NCH-1:0] pend = '0;
    logic sel_valid;
    logic [2:0] sel_ch;
    logic [12:0] tgt_data;
    logic [NCH-1:0] req_clr;
    logic wb_cyc, wb_stb, wb_we;
    logic [7:0] wb_adr, wb_dat_o;
    logic [7:0] wb_dat_i = '0;
    logic wb_ack = 1'b0;
    logic wr_prot;

    logic [12:0] chval [NCH];
    assign tgt_data = chval[sel_ch];

    vsq_setpoint_seq #(.NCH(NCH), .WAIT_TICKS(W)) dut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .req_pend(pend),
        .sel_valid(sel_valid), .sel_ch(sel_ch), .tgt_addr(TADDR),
        .tgt_ptr({5'b0, sel_ch}), .tgt_data(tgt_data), .req_clr(req_clr),
        .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
        .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i), .wb_ack(wb_ack), .wr_prot(wr_prot)
    );

    always #2 clk = ~clk;

    int checks = 0, failures = 0, cycles = 0;

    // model state and statistics
    logic [15:0] mem [NCH];
    logic        mtx_held = 1'b0;
    int  mtx_other = 0, mtx_lock_wr = 0;
    int  busy_cnt = 0, tip_cnt = 0, bcnt = 0;
    logic [7:0] txd = '0, ptr = '0, lo_buf = '0, rxd = '0;
    logic arbl_f = 1'b0, nack_f = 1'b0;
    int  arbl_inj = 0, nack_inj = 0, corrupt_inj = 0;
    int  arbl_seen = 0, arbl_reads = 0, arbl_wp_ok = 0;
    int  wr_start = 0, all_start = 0, clr_cnt = 0, cyc_seen = 0;
    int  viol_mtx = 0, viol_busy = 0, viol_wp = 0, viol_wb = 0;
    logic prev_pend_acc = 1'b0;
    logic [7:0] prev_adr = '0;
    int  sel_log [64];
    int  n_sel = 0;
    logic sel_prev = 1'b0;
    int  tick_div = 0;

    always @(posedge clk) begin
        cycles++;
        tick_div = (tick_div == 9) ? 0 : tick_div + 1;
        slow_tick <= (tick_div == 0);
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            wb_ack <= 1'b0;
            for (int i = 0; i < NCH; i++) mem[i] = '0;
        end else begin
            if (wb_cyc) cyc_seen++;
            if (req_clr != '0) begin clr_cnt++; pend = pend & ~req_clr; end
            if (sel_valid && !sel_prev && n_sel < 64) begin sel_log[n_sel] = int'(sel_ch); n_sel++; end
            sel_prev = sel_valid;
            if (prev_pend_acc && (!wb_stb || wb_adr != prev_adr)) viol_wb++;
            prev_pend_acc = wb_stb && !wb_ack;
            prev_adr = wb_adr;
            wb_ack <= wb_stb && !wb_ack;
            if (wb_stb && !wb_ack) begin
                if (wb_adr != A_MTX && !mtx_held) viol_mtx++;
                if (wb_we) begin
                    if (wb_adr == A_MTX) begin
                        if (wb_dat_o[7]) begin
                            mtx_lock_wr++;
                            if (mtx_other > 0) mtx_other--;
                            else if (wb_dat_o[6:0] == OWN) mtx_held = 1'b1;
                        end else if (wb_dat_o[6:0] == OWN) mtx_held = 1'b0;
                    end else if (wb_adr == A_TXD) begin
                        txd = wb_dat_o;
                    end else if (wb_adr == A_CMD) begin
                        arbl_f = 1'b0; nack_f = 1'b0; tip_cnt = 2; arbl_reads = 0;
                        if (wb_dat_o[0] && busy_cnt > 0) viol_busy++;
                        if (wb_dat_o[2]) begin
                            if (wb_dat_o[0]) begin
                                all_start++;
                                if (!wr_prot) wr_start++;
                                bcnt = 0;
                                if (nack_inj > 0) begin nack_inj--; nack_f = 1'b1; end
                                else if (txd[7:1] != TADDR) nack_f = 1'b1;
                            end else begin
                                if (bcnt == 0) ptr = txd;
                                else begin
                                    if (wr_prot) viol_wp++;
                                    if (bcnt == 1 && arbl_inj > 0) begin
                                        arbl_inj--; arbl_f = 1'b1; arbl_seen++; busy_cnt = 4;
                                    end else if (bcnt == 1) lo_buf = txd;
                                    else mem[ptr[2:0]] = {txd, lo_buf};
                                end
                                bcnt++;
                            end
                        end
                        if (wb_dat_o[3]) begin
                            if (bcnt == 0) rxd = mem[ptr[2:0]][7:0];
                            else begin
                                rxd = mem[ptr[2:0]][15:8];
                                if (corrupt_inj > 0) begin corrupt_inj--; rxd = rxd ^ 8'h01; end
                            end
                            bcnt++;
                        end
                    end
                end else begin
                    if (wb_adr == A_MTX) begin
                        wb_dat_i <= mtx_held ? {1'b1, OWN} : 8'h91;
                    end else if (wb_adr == A_STAT) begin
                        if (tip_cnt > 0) begin
                            tip_cnt--;
                            wb_dat_i <= 8'h02;
                        end else begin
                            if (arbl_f) begin
                                if (arbl_reads == 1 && wr_prot) arbl_wp_ok++;
                                arbl_reads++;
                            end
                            wb_dat_i <= {4'b0, nack_f, arbl_f, 1'b0, busy_cnt > 0};
                            if (busy_cnt > 0) busy_cnt--;
                        end
                    end else if (wb_adr == A_RXD) begin
                        wb_dat_i <= rxd;
                    end
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_idle();
        int t = 0;
        do begin @(negedge clk); t++; end while ((pend != '0 || sel_valid) && t < 30000);
        check(t < 30000, "R1 completion", t, 0);
    endtask

    task automatic request(input int ch, input logic [12:0] v);
        @(negedge clk);
        chval[ch] = v;
        pend[ch] = 1'b1;
    endtask

    task automatic t_reset();
        check(!sel_valid && !wb_cyc, "R1 reset idle", {sel_valid, wb_cyc}, 0);
        check(wr_prot == 1'b1, "R11 reset write-protect", wr_prot, 1);
        check(req_clr == '0, "R7 reset no retire", req_clr, 0);
    endtask

    task automatic t_idle();
        int c0 = cyc_seen;
        repeat (40) @(negedge clk);
        check(cyc_seen == c0 && !sel_valid, "R1 no bus cycle without request", cyc_seen - c0, 0);
    endtask

    task automatic t_basic();
        int s0 = all_start, w0 = wr_start, c0 = clr_cnt;
        request(2, 13'h1ABC);
        wait_idle();
        check(mem[2] == 16'h1ABC, "R5 stored word", mem[2], 16'h1ABC);
        check(wr_start - w0 == 1, "R5 one write phase", wr_start - w0, 1);
        check(all_start - s0 == 3, "R5 start count", all_start - s0, 3);
        check(clr_cnt - c0 == 1, "R7 retire on match", clr_cnt - c0, 1);
        check(viol_mtx == 0 && !mtx_held, "R3 mutex owned then released", viol_mtx, 0);
        check(viol_wp == 0, "R11 protect low during data", viol_wp, 0);
    endtask

    task automatic t_busy();
        @(negedge clk); busy_cnt = 6;
        request(4, 13'h0123);
        wait_idle();
        check(viol_busy == 0 && busy_cnt == 0, "R4 start only when idle", viol_busy, 0);
        check(mem[4] == 16'h0123, "R4 word after busy wait", mem[4], 16'h0123);
    endtask

    task automatic t_mutex();
        int m0 = mtx_lock_wr;
        @(negedge clk); mtx_other = 3;
        request(6, 13'h0F0F);
        wait_idle();
        check(mtx_lock_wr - m0 == 4, "R3 lock retried", mtx_lock_wr - m0, 4);
        check(viol_mtx == 0 && !mtx_held, "R3 no access before ownership", viol_mtx, 0);
        check(mem[6] == 16'h0F0F, "R3 word after contention", mem[6], 16'h0F0F);
    endtask

    task automatic t_arbl();
        int w0 = wr_start, c0 = clr_cnt, a0 = arbl_wp_ok;
        @(negedge clk); arbl_inj = 1;
        request(1, 13'h1555);
        wait_idle();
        check(wr_start - w0 == 2, "R6 write retransmitted", wr_start - w0, 2);
        check(arbl_wp_ok - a0 == 1, "R6 protect raised after loss", arbl_wp_ok - a0, 1);
        check(mem[1] == 16'h1555 && clr_cnt - c0 == 1, "R6 word after retry", mem[1], 16'h1555);
    endtask

    task automatic t_nack();
        int w0 = wr_start, c0 = clr_cnt;
        @(negedge clk); nack_inj = 1;
        request(3, 13'h0AAA);
        wait_idle();
        check(wr_start - w0 == 2, "R8 request kept after nack", wr_start - w0, 2);
        check(clr_cnt - c0 == 1 && !mtx_held, "R8 single retire, mutex free", clr_cnt - c0, 1);
        check(mem[3] == 16'h0AAA, "R8 word after retry", mem[3], 16'h0AAA);
    endtask

    task automatic t_mismatch();
        int w0 = wr_start, c0 = clr_cnt;
        @(negedge clk); corrupt_inj = 1;
        request(7, 13'h1F00);
        wait_idle();
        check(wr_start - w0 == 2, "R7 mismatch retried", wr_start - w0, 2);
        check(clr_cnt - c0 == 1, "R7 retire only on match", clr_cnt - c0, 1);
    endtask

    task automatic t_rr();
        int last = sel_log[n_sel - 1];
        int n0 = n_sel;
        logic [NCH-1:0] p = 8'b0100_1010;
        @(negedge clk);
        chval[1] = 13'h0011; chval[3] = 13'h0033; chval[6] = 13'h0066;
        pend = p;
        wait_idle();
        for (int k = 0; k < 3; k++) begin
            int e = -1;
            for (int j = 1; j <= NCH; j++) begin
                if (e < 0 && p[(last + j) % NCH]) e = (last + j) % NCH;
            end
            check(sel_log[n0 + k] == e, "R9 round-robin order", sel_log[n0 + k], e);
            p[e] = 1'b0;
            last = e;
        end
    endtask

    task automatic t_wait();
        int ticks = 0, gap = 0, t = 0;
        @(negedge clk);
        chval[5] = 13'h0555; chval[0] = 13'h0100;
        pend[5] = 1'b1; pend[0] = 1'b1;
        do begin @(negedge clk); t++; end while (req_clr == '0 && t < 30000);
        do begin
            @(negedge clk);
            if (!sel_valid) begin
                if (slow_tick) begin ticks++; gap = 0; end else gap++;
            end
        end while (!sel_valid && ticks <= W + 2);
        check(ticks == W, "R10 tick count between requests", ticks, W);
        check(gap <= 3, "R10 prompt start after last tick", gap, 3);
        wait_idle();
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) chval[i] = '0;
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_idle();
        t_basic();
        t_busy();
        t_mutex();
        t_arbl();
        t_nack();
        t_mismatch();
        t_rr();
        t_wait();
        check(viol_wb == 0, "R2 strobe held until ack", viol_wb, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        failures++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", cycles, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule